// File: doc/BRIEF.md
# Fetch-Stage Taken-Branch Target Cache

This block is a small, fully associative cache that the fetch unit consults with the current fetch address before the instruction has been decoded. Only branches known to have been taken are held. A lookup that matches a stored branch address therefore means "predicted taken", and the block gives the stored destination as the next fetch address in the same cycle. A lookup that finds nothing gives the sequential address, the fetch address plus four.

The branch resolution logic keeps the contents current through a single update port. A resolved taken branch that is not yet stored is inserted. The victim slot is chosen by a round-robin pointer. A stored branch that resolved taken to a new destination has its target rewritten. A stored branch that resolved not taken is removed. The lookup is purely combinational from the stored state, and updates take effect at the clock edge. A lookup in the same cycle as an update therefore sees the contents from before that update.

Top module: `btb_core`

## Requirements
- R1: While reset is asserted, and after it, every entry is invalid, so every lookup misses until a new entry is inserted.
- R2: On a miss, `pred_hit` is 0 and `next_pc` equals `fetch_pc + 4`, both in the same cycle as `fetch_pc`.
- R3: A lookup hits only when all AW bits of `fetch_pc` equal the stored branch address. An address that differs in any bit, including the most significant bit, misses.
- R4: After an update with `upd_valid`=1 and `upd_taken`=1 for an address that is not stored, a lookup of that address in a later cycle gives `pred_hit`=1 and `next_pc` equal to `upd_target`.
- R5: Inserts fill slots in order 0, 1, … ENTRIES-1 and then wrap to 0. The pointer starts at 0 after reset and advances only on an insert. With ENTRIES=8, the ninth insert evicts the first branch inserted.
- R6: An update with `upd_taken`=0 for a stored address removes it, so later lookups of that address miss.
- R7: An update with `upd_taken`=1 for a stored address replaces its target and does not move the round-robin pointer.
- R8: An update with `upd_taken`=0 for an address that is not stored changes nothing, and that address keeps missing.
- R9: When a lookup and an update refer to the same address in the same cycle, the lookup returns the contents from before the update.
- R10: At most one valid entry matches any fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears all valid bits and the victim pointer |
| fetch_pc | input | AW | Address of the instruction being fetched |
| pred_hit | output | 1 | 1 when `fetch_pc` matches a stored taken branch |
| next_pc | output | AW | Stored target on a hit, otherwise `fetch_pc + 4` |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | AW | Address of the resolved branch |
| upd_taken | input | 1 | 1 if the resolved branch was taken |
| upd_target | input | AW | Actual destination of the resolved branch |

## Verification
Both lookup outputs are combinational, so each one is due in the same cycle that `fetch_pc` is applied. The bench drives inputs on the falling edge and samples one time unit later, before the rising edge that commits any update. An update becomes visible one edge later, so the effect of an insert, refresh or removal is checked on the vector that follows it. Applying a lookup and an update to the same address in one vector covers R9 directly. Round-robin eviction and pointer behaviour are checked with directed sequences after a fresh reset.

// File: rtl/btb_core.sv
module btb_core #(
  parameter int AW      = 32,
  parameter int ENTRIES = 8,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_pc,
  output logic          pred_hit,
  output logic [AW-1:0] next_pc,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic [AW-1:0] upd_target
);

  logic [ENTRIES-1:0] vld;
  logic [AW-1:0]      tag_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];
  logic [IW-1:0]      vptr;

  logic [ENTRIES-1:0] f_match, u_match;
  logic [AW-1:0]      f_tgt;
  logic [IW-1:0]      u_idx;
  logic               u_hit, do_insert;

  always_comb begin
    f_tgt = '0;
    u_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      f_match[i] = vld[i] && (tag_q[i] == fetch_pc);
      u_match[i] = vld[i] && (tag_q[i] == upd_pc);
      if (f_match[i]) f_tgt = f_tgt | tgt_q[i];
      if (u_match[i]) u_idx = IW'(i);
    end
  end

  assign u_hit     = |u_match;
  assign do_insert = upd_valid && upd_taken && !u_hit;
  assign pred_hit  = |f_match;
  assign next_pc   = pred_hit ? f_tgt : fetch_pc + AW'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      vptr <= '0;
    end else if (upd_valid) begin
      if (u_hit && !upd_taken) begin
        vld[u_idx] <= 1'b0;
      end else if (do_insert) begin
        vld[vptr] <= 1'b1;
        vptr      <= (vptr == IW'(ENTRIES-1)) ? '0 : vptr + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_valid && upd_taken) begin
      if (u_hit) begin
        tgt_q[u_idx] <= upd_target;
      end else begin
        tag_q[vptr] <= upd_pc;
        tgt_q[vptr] <= upd_target;
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(f_match) <= 1); // R10

  AST_INSERT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      ((fetch_pc != $past(upd_pc)) || (pred_hit && next_pc == $past(upd_target)))); // R4

  AST_NOT_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> ((fetch_pc != $past(upd_pc)) || !pred_hit)); // R6

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_taken) |=> $stable(vptr)); // R5

endmodule

// File: tb/btb_core_test.sv
module btb_core_test;
  localparam int CLK_P = 10;
  localparam int AW    = 32;
  localparam int NV    = 12;

  // {req[4], uv, ut, upc[32], utg[32], fpc[32], exp_hit, exp_next[32]}
  localparam logic [134:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b0, 32'h0,   32'h0,   32'h100,      1'b0, 32'h104},      // R1 empty
    {4'd9, 1'b1, 1'b1, 32'h100, 32'h800, 32'h100,      1'b0, 32'h104},      // R9 insert, old view
    {4'd4, 1'b0, 1'b0, 32'h0,   32'h0,   32'h100,      1'b1, 32'h800},      // R4 inserted
    {4'd2, 1'b0, 1'b0, 32'h0,   32'h0,   32'h104,      1'b0, 32'h108},      // R2 miss
    {4'd3, 1'b0, 1'b0, 32'h0,   32'h0,   32'h80000100, 1'b0, 32'h80000104}, // R3 full compare
    {4'd8, 1'b1, 1'b0, 32'h200, 32'h700, 32'h200,      1'b0, 32'h204},      // R8 not-taken miss
    {4'd8, 1'b0, 1'b0, 32'h0,   32'h0,   32'h200,      1'b0, 32'h204},      // R8 no effect
    {4'd9, 1'b1, 1'b1, 32'h100, 32'h900, 32'h100,      1'b1, 32'h800},      // R9 refresh, old view
    {4'd7, 1'b0, 1'b0, 32'h0,   32'h0,   32'h100,      1'b1, 32'h900},      // R7 new target
    {4'd4, 1'b1, 1'b1, 32'h300, 32'hA00, 32'h100,      1'b1, 32'h900},      // R4 second insert
    {4'd6, 1'b1, 1'b0, 32'h300, 32'h0,   32'h300,      1'b1, 32'hA00},      // R6 remove, old view
    {4'd6, 1'b0, 1'b0, 32'h0,   32'h0,   32'h300,      1'b0, 32'h304}       // R6 removed
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          pred_hit;
  logic [AW-1:0] next_pc;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;
  logic [AW-1:0] upd_target = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  btb_core #(.AW(AW), .ENTRIES(8)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .next_pc(next_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input int req, input logic eh, input logic [AW-1:0] en);
    n_chk++;
    if (pred_hit !== eh || next_pc !== en) begin
      n_bad++;
      $display("FAIL R%0d: hit=%0b next=%h, expected hit=%0b next=%h",
               req, pred_hit, next_pc, eh, en);
    end
  endtask

  task automatic step(input logic uv, input logic ut, input logic [AW-1:0] upc,
                      input logic [AW-1:0] utg, input logic [AW-1:0] fpc);
    @(negedge clk);
    upd_valid = uv; upd_taken = ut; upd_pc = upc; upd_target = utg; fetch_pc = fpc;
    #1;
  endtask

  task automatic look(input int req, input logic [AW-1:0] fpc,
                      input logic eh, input logic [AW-1:0] en);
    step(1'b0, 1'b0, '0, '0, fpc);
    check(req, eh, en);
  endtask

  task automatic put(input logic [AW-1:0] pc, input logic [AW-1:0] tg);
    step(1'b1, 1'b1, pc, tg, 32'hFFF0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    fetch_pc = 32'h40;
    #(CLK_P * 2 + 1);
    check(1, 1'b0, 32'h44); // R1 during reset
    do_reset();

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][130], VEC[k][129], VEC[k][128:97], VEC[k][96:65], VEC[k][64:33]);
      check(int'(VEC[k][134:131]), VEC[k][32], VEC[k][31:0]);
    end

    // R5 round-robin fill and wrap
    do_reset();
    for (int i = 0; i < 8; i++) put(32'h1000 + 32'(i*16), 32'h5000 + 32'(i*16));
    for (int i = 0; i < 8; i++) look(5, 32'h1000 + 32'(i*16), 1'b1, 32'h5000 + 32'(i*16));
    put(32'h2000, 32'h6000);
    look(5, 32'h1000, 1'b0, 32'h1004);
    look(5, 32'h1010, 1'b1, 32'h5010);
    look(5, 32'h2000, 1'b1, 32'h6000);

    // R7 refresh keeps pointer: next insert evicts slot 1
    put(32'h1010, 32'h7000);
    look(7, 32'h1010, 1'b1, 32'h7000);
    put(32'h2100, 32'h6100);
    look(7, 32'h1010, 1'b0, 32'h1014);
    look(7, 32'h1020, 1'b1, 32'h5020);
    look(7, 32'h2100, 1'b1, 32'h6100);

    // R1 reset clears stored entries
    do_reset();
    look(1, 32'h1030, 1'b0, 32'h1034);
    look(1, 32'h2000, 1'b0, 32'h2004);

    finish_run();
  end
endmodule